// File: doc/BRIEF.md
# CAN Error-State Flag Register

This block is the receive-side flag register of a CAN controller. It watches the transmit and receive error counters and converts each into a two-bit bus-state code. When either code moves into a different range, the block publishes the new codes and raises a status-change flag. While that flag is pending, the published codes stay frozen, however far the counters move. Once software clears the flag, the codes are reloaded from the counters on the following cycle, and the flag is raised again if they differ.

The register also holds three event flags. The wake-up flag records bus activity seen while the controller sleeps with wake-up enabled. The overrun flag and the receive-full flag record events from the receive path. Software clears any flag by writing a 1 to its bit. While the controller is in initialization mode, the flags are held at zero and writes are ignored, but the bus-state codes keep their values.

Top module: `can_errstate_flags`

## Requirements
- R1: After reset, `rd_data` reads 0x00. The layout is bit 7 wake-up, bit 6 status change, bits 5:4 receiver code, bits 3:2 transmitter code, bit 1 overrun and bit 0 receive-full.
- R2: The receiver code is 00 for a receive count of 0 to 96, 01 for 97 to 127, and 10 for any count above 127.
- R3: The transmitter code is 00 for a transmit count of 0 to 96, 01 for 97 to 127, 10 for 128 to 255, and 11 (bus-off) above 255. While the transmitter is bus-off, the receiver code also reads 11.
- R4: When no change flag is pending and a computed code differs from the published one, the next clock edge publishes both computed codes and sets bit 6.
- R5: While bit 6 is set, bits 5:2 keep their value, whatever the counters do.
- R6: In the cycle after bit 6 is cleared, the codes still show their old values. On the edge after that, they reload from the counters, and bit 6 is set again if they changed.
- R7: Writing 1 to bit 7, 6, 1 or 0 clears that flag. Writing 0 leaves it unchanged. Writes never alter bits 5:2.
- R8: When a hardware set event and a write-1 clear hit the same flag in the same cycle, the flag stays 1.
- R9: While `init_req` and `init_ack` are both high, bits 7, 6, 1 and 0 are held at 0, set events are discarded, and bits 5:2 keep their value. Writes take effect only while both signals are low.
- R10: The wake-up flag is set only when `bus_activity`, `sleep_mode` and `wake_en` are all high in the same cycle.
- R11: A pulse on `overrun_evt` sets bit 1, and a pulse on `rx_full_evt` sets bit 0. Each is visible one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_err_cnt | input | CNT_W | Transmit error counter value |
| rx_err_cnt | input | CNT_W | Receive error counter value |
| init_req | input | 1 | Initialization-mode request |
| init_ack | input | 1 | Initialization-mode acknowledge |
| sleep_mode | input | 1 | Controller is asleep |
| wake_en | input | 1 | Wake-up on bus activity enabled |
| bus_activity | input | 1 | Bus activity detected |
| overrun_evt | input | 1 | Receive overrun event pulse |
| rx_full_evt | input | 1 | Receive buffer filled event pulse |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data, 1 bits clear flags |
| rd_data | output | 8 | Register read value |

## Verification
Two things can land on the same flag in the same cycle: a hardware set event and a software write-1 clear. The bench drives an overrun pulse and a write of 0x02 in one cycle and expects bit 1 to read 1 on the next cycle. It then clears the flag alone to show that the write path works. A second pairing is the clear of the status-change flag while the counters sit in a new range. Here the bench expects the old codes for one cycle, then a fresh change flag carrying the new codes on the cycle after.

// File: rtl/can_errstate_pkg.sv
package can_errstate_pkg;

    localparam int REG_W   = 8;
    localparam int BIT_WAKE = 7;
    localparam int BIT_CHG  = 6;
    localparam int BIT_OVR  = 1;
    localparam int BIT_RXF  = 0;

    typedef enum logic [1:0] {
        BS_OK      = 2'b00,
        BS_WARN    = 2'b01,
        BS_PASSIVE = 2'b10,
        BS_OFF     = 2'b11
    } bus_state_e;

    // Packed in register order, MSB first
    typedef struct packed {
        logic       wake;
        logic       chg;
        bus_state_e rx;
        bus_state_e tx;
        logic       ovr;
        logic       rxf;
    } flagreg_t;

endpackage

// File: rtl/can_errstate_classify.sv
module can_errstate_classify
    import can_errstate_pkg::*;
#(
    parameter int CNT_W       = 9,
    parameter int WARN_LIM    = 96,
    parameter int PASSIVE_LIM = 127,
    parameter int BUSOFF_LIM  = 255
) (
    input  logic [CNT_W-1:0] cnt_i,
    output bus_state_e       state_o
);

    localparam logic [CNT_W-1:0] WARN_C    = CNT_W'(WARN_LIM);
    localparam logic [CNT_W-1:0] PASSIVE_C = CNT_W'(PASSIVE_LIM);
    localparam logic [CNT_W-1:0] BUSOFF_C  = CNT_W'(BUSOFF_LIM);

    always_comb begin
        if (cnt_i <= WARN_C)         state_o = BS_OK;
        else if (cnt_i <= PASSIVE_C) state_o = BS_WARN;
        else if (cnt_i <= BUSOFF_C)  state_o = BS_PASSIVE;
        else                         state_o = BS_OFF;
    end

endmodule

// File: rtl/can_errstate_events.sv
module can_errstate_events
    import can_errstate_pkg::*;
(
    input  logic             sleep_mode,
    input  logic             wake_en,
    input  logic             bus_activity,
    input  logic             overrun_evt,
    input  logic             rx_full_evt,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             wr_open,
    output logic [REG_W-1:0] set_mask,
    output logic [REG_W-1:0] clr_mask
);

    localparam logic [REG_W-1:0] W1C_MASK =
        REG_W'((1 << BIT_WAKE) | (1 << BIT_CHG) | (1 << BIT_OVR) | (1 << BIT_RXF));

    always_comb begin
        set_mask           = '0;
        set_mask[BIT_WAKE] = bus_activity & sleep_mode & wake_en;
        set_mask[BIT_OVR]  = overrun_evt;
        set_mask[BIT_RXF]  = rx_full_evt;
        clr_mask           = (wr_en && wr_open) ? (wr_data & W1C_MASK) : '0;
    end

endmodule

// File: rtl/can_errstate_flags.sv
module can_errstate_flags
    import can_errstate_pkg::*;
#(
    parameter int CNT_W       = 9,
    parameter int WARN_LIM    = 96,
    parameter int PASSIVE_LIM = 127,
    parameter int BUSOFF_LIM  = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tx_err_cnt,
    input  logic [CNT_W-1:0] rx_err_cnt,
    input  logic             init_req,
    input  logic             init_ack,
    input  logic             sleep_mode,
    input  logic             wake_en,
    input  logic             bus_activity,
    input  logic             overrun_evt,
    input  logic             rx_full_evt,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data
);

    bus_state_e        rx_raw, tx_raw, rx_calc, tx_calc;
    logic              init_active, wr_open;
    logic [REG_W-1:0]  set_mask, clr_mask;
    flagreg_t          reg_d, reg_q;

    assign init_active = init_req & init_ack;
    assign wr_open     = ~init_req & ~init_ack;

    can_errstate_classify #(
        .CNT_W(CNT_W), .WARN_LIM(WARN_LIM),
        .PASSIVE_LIM(PASSIVE_LIM), .BUSOFF_LIM(BUSOFF_LIM)
    ) u_rx_class (
        .cnt_i   (rx_err_cnt),
        .state_o (rx_raw)
    );

    can_errstate_classify #(
        .CNT_W(CNT_W), .WARN_LIM(WARN_LIM),
        .PASSIVE_LIM(PASSIVE_LIM), .BUSOFF_LIM(BUSOFF_LIM)
    ) u_tx_class (
        .cnt_i   (tx_err_cnt),
        .state_o (tx_raw)
    );

    can_errstate_events u_events (
        .sleep_mode   (sleep_mode),
        .wake_en      (wake_en),
        .bus_activity (bus_activity),
        .overrun_evt  (overrun_evt),
        .rx_full_evt  (rx_full_evt),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .wr_open      (wr_open),
        .set_mask     (set_mask),
        .clr_mask     (clr_mask)
    );

    // Bus-off is a transmitter condition mirrored into the receiver field;
    // the receiver alone never goes beyond the passive range.
    always_comb begin
        tx_calc = tx_raw;
        if (tx_raw == BS_OFF)      rx_calc = BS_OFF;
        else if (rx_raw == BS_OFF) rx_calc = BS_PASSIVE;
        else                       rx_calc = rx_raw;
    end

    always_comb begin
        reg_d = reg_q;
        if (init_active) begin
            reg_d.wake = 1'b0;
            reg_d.chg  = 1'b0;
            reg_d.ovr  = 1'b0;
            reg_d.rxf  = 1'b0;
        end else begin
            reg_d.wake = set_mask[BIT_WAKE] | (reg_q.wake & ~clr_mask[BIT_WAKE]);
            reg_d.ovr  = set_mask[BIT_OVR]  | (reg_q.ovr  & ~clr_mask[BIT_OVR]);
            reg_d.rxf  = set_mask[BIT_RXF]  | (reg_q.rxf  & ~clr_mask[BIT_RXF]);
            if (reg_q.chg) begin
                reg_d.chg = ~clr_mask[BIT_CHG];
            end else if ((rx_calc != reg_q.rx) || (tx_calc != reg_q.tx)) begin
                reg_d.chg = 1'b1;
                reg_d.rx  = rx_calc;
                reg_d.tx  = tx_calc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    assign rd_data = reg_q;

endmodule

// File: rtl/can_errstate_flags_chk.sv
module can_errstate_flags_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       init_req,
    input logic       init_ack,
    input logic       sleep_mode,
    input logic       wake_en,
    input logic       bus_activity,
    input logic       overrun_evt,
    input logic       rx_full_evt,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data
);

    a_r4_code_move_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data[5:2]) |-> rd_data[6]);

    a_r5_codes_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[6] |=> $stable(rd_data[5:2]));

    a_r9_init_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (init_req && init_ack) |=> (rd_data[7:6] == 2'b00 && rd_data[1:0] == 2'b00));

    a_r9_init_keeps_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (init_req && init_ack) |=> $stable(rd_data[5:2]));

    a_r8_overrun_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_evt && !(init_req && init_ack)) |=> rd_data[1]);

    a_r11_rxfull_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full_evt && !(init_req && init_ack)) |=> rd_data[0]);

    a_r10_wake_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[7]) |-> $past(bus_activity && sleep_mode && wake_en));

    a_r7_overrun_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_data[1]) |->
            $past((wr_en && wr_data[1] && !init_req && !init_ack) || (init_req && init_ack)));

endmodule

bind can_errstate_flags can_errstate_flags_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .init_req     (init_req),
    .init_ack     (init_ack),
    .sleep_mode   (sleep_mode),
    .wake_en      (wake_en),
    .bus_activity (bus_activity),
    .overrun_evt  (overrun_evt),
    .rx_full_evt  (rx_full_evt),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data)
);

// File: tb/tb_can_errstate_flags.sv
`timescale 1ns/1ps
module tb_can_errstate_flags;

    localparam int CNT_W = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] tx_err_cnt = '0;
    logic [CNT_W-1:0] rx_err_cnt = '0;
    logic             init_req = 1'b0, init_ack = 1'b0;
    logic             sleep_mode = 1'b0, wake_en = 1'b0, bus_activity = 1'b0;
    logic             overrun_evt = 1'b0, rx_full_evt = 1'b0;
    logic             wr_en = 1'b0;
    logic [7:0]       wr_data = '0;
    logic [7:0]       rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    can_errstate_flags #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt),
        .init_req(init_req), .init_ack(init_ack), .sleep_mode(sleep_mode),
        .wake_en(wake_en), .bus_activity(bus_activity), .overrun_evt(overrun_evt),
        .rx_full_evt(rx_full_evt), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [7:0] exp);
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s: rd_data=0x%02h expected 0x%02h", req, rd_data, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic set_cnt(input int tx, input int rx);
        tx_err_cnt = CNT_W'(tx);
        rx_err_cnt = CNT_W'(rx);
        cyc();
    endtask

    task automatic wr(input logic [7:0] v);
        wr_en = 1'b1;
        wr_data = v;
        cyc();
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic t_reset();
        check("R1 reset value", 8'h00);
    endtask

    task automatic t_rx_codes();
        set_cnt(0, 96);  check("R2 rx 96 stays ok", 8'h00);
        set_cnt(0, 97);  check("R2 rx 97 warn", 8'h50);
        wr(8'h40);       check("R2 clear change", 8'h10);
        cyc();           check("R2 no re-raise", 8'h10);
        set_cnt(0, 127); check("R2 rx 127 still warn", 8'h10);
        set_cnt(0, 128); check("R2 rx 128 passive", 8'h60);
        wr(8'h40);       check("R2 clear", 8'h20);
        set_cnt(0, 0);   check("R2 rx back to ok", 8'h40);
        wr(8'h40);       check("R2 clear", 8'h00);
    endtask

    task automatic t_tx_codes();
        set_cnt(97, 0);  check("R3 tx 97 warn", 8'h44);
        wr(8'h40);       check("R3 clear", 8'h04);
        set_cnt(128, 0); check("R3 tx 128 passive", 8'h48);
        wr(8'h40);       check("R3 clear", 8'h08);
        set_cnt(255, 0); check("R3 tx 255 still passive", 8'h08);
        set_cnt(256, 50); check("R3 tx 256 bus-off both fields", 8'h7C);
        wr(8'h40);       check("R3 clear", 8'h3C);
        set_cnt(0, 0);   check("R3 recovery", 8'h40);
        wr(8'h40);       check("R3 clear", 8'h00);
    endtask

    task automatic t_freeze();
        set_cnt(0, 100); check("R4 change published", 8'h50);
        set_cnt(0, 200); check("R5 frozen while pending", 8'h50);
        cyc();           check("R5 still frozen", 8'h50);
        wr(8'h40);       check("R6 old codes one cycle", 8'h10);
        cyc();           check("R6 reload re-raises", 8'h60);
        wr(8'h40);       check("R6 clear", 8'h20);
        cyc();           check("R6 stable after clear", 8'h20);
        set_cnt(0, 0);   check("R4 back to ok", 8'h40);
        wr(8'h40);       check("R4 clear", 8'h00);
    endtask

    task automatic t_w1c();
        overrun_evt = 1'b1; rx_full_evt = 1'b1; cyc();
        overrun_evt = 1'b0; rx_full_evt = 1'b0;
        check("R11 events set flags", 8'h03);
        wr(8'h00);       check("R7 write 0 no effect", 8'h03);
        wr(8'h3C);       check("R7 code bits unaffected", 8'h03);
        wr(8'h02);       check("R7 clear overrun only", 8'h01);
        wr(8'h01);       check("R7 clear rx-full", 8'h00);
    endtask

    task automatic t_set_wins();
        overrun_evt = 1'b1; cyc(); overrun_evt = 1'b0;
        check("R8 overrun set", 8'h02);
        overrun_evt = 1'b1; wr(8'h02); overrun_evt = 1'b0;
        check("R8 set wins over clear", 8'h02);
        wr(8'h02);       check("R8 clear alone", 8'h00);
    endtask

    task automatic t_wake();
        bus_activity = 1'b1; cyc();
        check("R10 awake activity ignored", 8'h00);
        sleep_mode = 1'b1; cyc();
        check("R10 wake disabled ignored", 8'h00);
        wake_en = 1'b1; cyc();
        bus_activity = 1'b0;
        check("R10 wake set", 8'h80);
        wr(8'h80);       check("R10 wake cleared", 8'h00);
        sleep_mode = 1'b0; wake_en = 1'b0;
    endtask

    task automatic t_init();
        set_cnt(0, 100); wr(8'h40);
        check("R9 setup codes", 8'h10);
        overrun_evt = 1'b1; cyc(); overrun_evt = 1'b0;
        check("R9 setup overrun", 8'h12);
        init_req = 1'b1;
        wr(8'h02);       check("R9 write ignored during request", 8'h12);
        init_ack = 1'b1; cyc();
        check("R9 flags held, codes kept", 8'h10);
        overrun_evt = 1'b1; set_cnt(0, 0); overrun_evt = 1'b0;
        check("R9 events and counters ignored", 8'h10);
        init_req = 1'b0; init_ack = 1'b0; cyc();
        check("R9 change after exit", 8'h40);
        wr(8'h40);       check("R9 writable after exit", 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_rx_codes();
        t_tx_codes();
        t_freeze();
        t_w1c();
        t_set_wins();
        t_wake();
        t_init();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule